// File: doc/BRIEF.md
# Cycle-Counting Timer Interrupt Unit

This block is an interval timer that counts processor cycles and raises an interrupt when its count runs out. Each clock edge of `clk` is one processor cycle. Software sets a 16-bit reload value through two byte-wide writes. It then writes a control byte that starts the counter and selects between a single expiry and periodic expiry. The block holds the interrupt as a pending flag. Software clears that flag by reading the status location, by stopping the timer, or by dropping the master disk-I/O enable.

The counter loads from the reload value only when a control write sets the enable bit. While the timer runs, the counter steps down once per cycle. On a cycle where the counter already stands at zero, three things happen: the flag is set, the counter is refilled from the reload value, and, in single-expiry mode, the timer stops. A reload value of N therefore spaces expiries N+1 cycles apart. The master enable gates the control byte only. The two reload bytes can be written at any time.

Top module: `cyc_timer_irq`

## Requirements
- R1: After reset `irq` and `stat_timer` are 0, and the reload value, counter, run and repeat state are cleared. `stat_timer` always equals `irq`.
- R2: A write with `wr_sel` = 0 sets the low reload byte and `wr_sel` = 1 sets the high reload byte. Both writes take effect whatever the value of `io_master_en`.
- R3: A control write (`wr_sel` = 2) with data bit 1 (enable) set and `io_master_en` high loads the counter with the reload value. With reload value N, `irq` first reads 1 after the (N+1)-th clock edge that follows the write edge.
- R4: The high reload byte carries weight 256. Low = 0 and high = 1 gives a first expiry after 257 edges.
- R5: With data bit 0 (repeat) clear, the timer stops after its first expiry. Once that expiry is acknowledged, no further interrupt occurs.
- R6: With repeat set, the timer reloads on expiry and expires again every N+1 cycles.
- R7: With reload value 0 and repeat set, the timer expires on every cycle once it has started.
- R8: A status read strobe (`stat_rd`) clears the pending flag from the following edge on.
- R9: If an expiry falls on the same edge as a status read, the flag stays set.
- R10: A control write with the enable bit clear stops the timer and clears the pending flag at that edge.
- R11: A control write has no effect while `io_master_en` is low. The timer does not start, even after the master enable returns.
- R12: While `io_master_en` is low, the timer is stopped and the pending flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor-cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 reload low, 1 reload high, 2 control, 3 none |
| wr_data | input | 8 | Write data byte |
| stat_rd | input | 1 | Status read strobe (acknowledge) |
| io_master_en | input | 1 | Master disk-I/O enable |
| irq | output | 1 | Active-high interrupt request (registered pending flag) |
| stat_timer | output | 1 | Status bit 0: timer interrupt pending |

## Verification
With reload N, a starting write sampled on edge k makes `irq` rise after edge k+N+1. Acknowledges from a status read, a control clear or the master enable are visible one edge after the strobe. The bench drives every input on the falling edge, so each one is sampled by exactly one rising edge. It compares the ports against a behavioural model on every falling edge, so a result due on a given edge is checked half a cycle after that edge. The directed checks count falling edges from the write edge. At N and at N+1 they confirm the exact cycle of the rise rather than a window.

// File: rtl/cti_pkg.sv
package cti_pkg;
  // write target selection
  typedef enum logic [1:0] {
    SEL_RELOAD_LO = 2'd0,
    SEL_RELOAD_HI = 2'd1,
    SEL_CONTROL   = 2'd2,
    SEL_NONE      = 2'd3
  } cti_sel_e;

  // control byte bit positions
  localparam int unsigned CTL_REPEAT_BIT = 0;
  localparam int unsigned CTL_ENABLE_BIT = 1;

  // next state of the pending flag: expiry wins over every acknowledge
  function automatic logic cti_next_pend(input logic cur, input logic expire, input logic ack);
    if (expire)   return 1'b1;
    else if (ack) return 1'b0;
    else          return cur;
  endfunction
endpackage

// File: rtl/cti_reload.sv
module cti_reload #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LANES  = 2,
  localparam int unsigned VAL_W = DATA_W * LANES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LANES-1:0]   lane_we,
  input  logic [DATA_W-1:0]  wdata,
  output logic [VAL_W-1:0]   reload
);
  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic [DATA_W-1:0] lane_q;
    always_ff @(posedge clk) begin
      if (!rst_n)          lane_q <= '0;
      else if (lane_we[b]) lane_q <= wdata;
    end
    assign reload[b*DATA_W +: DATA_W] = lane_q;
  end
endmodule

// File: rtl/cti_core.sv
module cti_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master_en,
  input  logic             ctl_wr,
  input  logic             ctl_enable,
  input  logic             ctl_repeat,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             run,
  output logic             rep,
  output logic             expire
);
  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v);
    return v - {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction

  logic at_zero;
  assign at_zero = (count == '0);
  assign expire  = master_en && !ctl_wr && run && at_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      run   <= 1'b0;
      rep   <= 1'b0;
    end else if (!master_en) begin
      run <= 1'b0;
    end else if (ctl_wr) begin
      run <= ctl_enable;
      rep <= ctl_repeat;
      if (ctl_enable) count <= reload;
    end else if (run) begin
      if (at_zero) begin
        count <= reload;
        if (!rep) run <= 1'b0;
      end else begin
        count <= step_down(count);
      end
    end
  end
endmodule

// File: rtl/cti_flag.sv
module cti_flag
  import cti_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic ack,
  output logic pend
);
  always_ff @(posedge clk) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= cti_next_pend(pend, expire, ack);
  end
endmodule

// File: rtl/cyc_timer_irq.sv
module cyc_timer_irq
  import cti_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned LANES = 2,
  localparam int unsigned CNT_W = DATA_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              stat_rd,
  input  logic              io_master_en,
  output logic              irq,
  output logic              stat_timer
);
  // named internal events, visible to the bound checker
  logic             ctl_hit;
  logic             ctl_stop_ack;
  logic             any_ack;
  logic             expire_evt;
  logic [LANES-1:0] lane_we;
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] count;
  logic             run;
  logic             rep;
  logic             pend;

  assign ctl_hit      = wr_en && (wr_sel == SEL_CONTROL) && io_master_en;
  assign ctl_stop_ack = ctl_hit && !wr_data[CTL_ENABLE_BIT];
  assign any_ack      = stat_rd || ctl_stop_ack || !io_master_en;

  assign lane_we[0] = wr_en && (wr_sel == SEL_RELOAD_LO);
  assign lane_we[1] = wr_en && (wr_sel == SEL_RELOAD_HI);

  cti_reload #(.DATA_W(DATA_W), .LANES(LANES)) u_reload (
    .clk     (clk),
    .rst_n   (rst_n),
    .lane_we (lane_we),
    .wdata   (wr_data),
    .reload  (reload)
  );

  cti_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .master_en  (io_master_en),
    .ctl_wr     (ctl_hit),
    .ctl_enable (wr_data[CTL_ENABLE_BIT]),
    .ctl_repeat (wr_data[CTL_REPEAT_BIT]),
    .reload     (reload),
    .count      (count),
    .run        (run),
    .rep        (rep),
    .expire     (expire_evt)
  );

  cti_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .expire (expire_evt),
    .ack    (any_ack),
    .pend   (pend)
  );

  assign irq        = pend;
  assign stat_timer = pend;
endmodule

// File: rtl/cti_checker.sv
module cti_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic             wr_en_bit,
  input logic             stat_rd,
  input logic             io_master_en,
  input logic             irq,
  input logic             stat_timer,
  input logic [CNT_W-1:0] reload,
  input logic [CNT_W-1:0] count,
  input logic             run,
  input logic             rep,
  input logic             expire_evt
);
  logic ctl_write;
  assign ctl_write = wr_en && (wr_sel == 2'd2);

  a_r1_status_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    stat_timer == irq);

  a_r3_load_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_write && io_master_en && wr_en_bit) |=> (run && count == $past(reload)));

  a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (run && io_master_en && !ctl_write && count != '0) |=> (count == CNT_W'($past(count) - 1'b1)));

  a_r5_one_shot_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_evt && !rep) |=> !run);

  a_r6_refill_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> (count == $past(reload)));

  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !expire_evt) |=> !irq);

  a_r9_expiry_sets: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> irq);

  a_r10_stop_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_write && io_master_en && !wr_en_bit) |=> (!irq && !run));

  a_r11_ctl_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_write && !io_master_en) |=> !run);

  a_r12_master_off: assert property (@(posedge clk) disable iff (!rst_n)
    !io_master_en |=> (!irq && !run));
endmodule

bind cyc_timer_irq cti_checker #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_sel       (wr_sel),
  .wr_en_bit    (wr_data[1]),
  .stat_rd      (stat_rd),
  .io_master_en (io_master_en),
  .irq          (irq),
  .stat_timer   (stat_timer),
  .reload       (reload),
  .count        (count),
  .run          (run),
  .rep          (rep),
  .expire_evt   (expire_evt)
);

// File: tb/tb_cyc_timer_irq.sv
`timescale 1ns/1ps
module tb_cyc_timer_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd3;
  logic [7:0] wr_data = 8'h00;
  logic       stat_rd = 1'b0;
  logic       io_master_en = 1'b0;
  logic       irq;
  logic       stat_timer;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  cyc_timer_irq dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .stat_rd(stat_rd), .io_master_en(io_master_en), .irq(irq), .stat_timer(stat_timer)
  );

  // behavioural reference
  int m_rel = 0, m_cnt = 0;
  bit m_run = 0, m_rep = 0, m_pend = 0;

  always @(posedge clk) begin
    bit fired, npend;
    int nrel;
    fired = 0;
    if (!rst_n) begin
      m_rel = 0; m_cnt = 0; m_run = 0; m_rep = 0; m_pend = 0;
    end else begin
      npend = m_pend;
      nrel  = m_rel;
      if (wr_en && wr_sel == 2'd0) nrel = (m_rel / 256) * 256 + wr_data;
      if (wr_en && wr_sel == 2'd1) nrel = wr_data * 256 + (m_rel % 256);
      if (!io_master_en) begin
        m_run = 0; npend = 0;
      end else if (wr_en && wr_sel == 2'd2) begin
        m_rep = wr_data[0];
        m_run = wr_data[1];
        if (wr_data[1]) m_cnt = m_rel; else npend = 0;
      end else if (m_run) begin
        if (m_cnt == 0) begin
          fired = 1; m_cnt = m_rel;
          if (!m_rep) m_run = 0;
        end else m_cnt = m_cnt - 1;
      end
      if (stat_rd) npend = 0;
      if (fired) npend = 1;
      m_pend = npend;
      m_rel  = nrel;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (irq !== m_pend || stat_timer !== m_pend) begin
        fails++;
        $display("FAIL %s cycle model: irq=%b stat=%b expected %b at %0t", cur_req, irq, stat_timer, m_pend, $time);
      end
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 2'd3; wr_data = 8'h00;
  endtask

  task automatic rd();
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not end");
      finish_run();
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    cur_req = "R1";
    chk("R1", irq, 1'b0);
    chk("R1", stat_timer, 1'b0);

    // R2: reload written with master off; R3 timing with N=4
    cur_req = "R2";
    wr(2'd0, 8'd4);
    wr(2'd1, 8'd0);
    io_master_en = 1'b1;
    tick(1);
    cur_req = "R3";
    wr(2'd2, 8'h02);
    tick(4);
    chk("R3", irq, 1'b0);
    tick(1);
    chk("R3", irq, 1'b1);
    chk("R2", stat_timer, 1'b1);
    tick(10);
    chk("R5", irq, 1'b1);
    cur_req = "R8";
    rd();
    chk("R8", irq, 1'b0);
    cur_req = "R5";
    tick(20);
    chk("R5", irq, 1'b0);

    // R6: repeat with N=3
    cur_req = "R6";
    wr(2'd0, 8'd3);
    wr(2'd2, 8'h03);
    tick(3);
    chk("R6", irq, 1'b0);
    tick(1);
    chk("R6", irq, 1'b1);
    rd();
    chk("R8", irq, 1'b0);
    tick(2);
    chk("R6", irq, 1'b0);
    tick(1);
    chk("R6", irq, 1'b1);

    // R10: control write with enable clear acknowledges and stops
    cur_req = "R10";
    wr(2'd2, 8'h00);
    chk("R10", irq, 1'b0);
    tick(20);
    chk("R10", irq, 1'b0);

    // R7 / R9: zero reload repeat, reads held every cycle
    cur_req = "R7";
    wr(2'd0, 8'd0);
    wr(2'd2, 8'h03);
    chk("R7", irq, 1'b0);
    tick(1);
    chk("R7", irq, 1'b1);
    cur_req = "R9";
    stat_rd = 1'b1;
    tick(5);
    chk("R9", irq, 1'b1);
    stat_rd = 1'b0;
    cur_req = "R10";
    wr(2'd2, 8'h00);
    chk("R10", irq, 1'b0);

    // R11: control write ignored while master off
    cur_req = "R11";
    io_master_en = 1'b0;
    wr(2'd0, 8'd2);
    wr(2'd2, 8'h03);
    tick(10);
    chk("R11", irq, 1'b0);
    io_master_en = 1'b1;
    tick(10);
    chk("R11", irq, 1'b0);

    // R12: dropping master enable acknowledges and stops
    cur_req = "R12";
    wr(2'd0, 8'd10);
    wr(2'd2, 8'h03);
    tick(11);
    chk("R12", irq, 1'b1);
    io_master_en = 1'b0;
    tick(1);
    chk("R12", irq, 1'b0);
    io_master_en = 1'b1;
    tick(30);
    chk("R12", irq, 1'b0);

    // R4: high byte weight
    cur_req = "R4";
    wr(2'd0, 8'd0);
    wr(2'd1, 8'd1);
    wr(2'd2, 8'h02);
    tick(256);
    chk("R4", irq, 1'b0);
    tick(1);
    chk("R4", irq, 1'b1);
    rd();
    tick(300);
    chk("R5", irq, 1'b0);

    finish_run();
  end
endmodule